// File: doc/BRIEF.md
# Memory-Mapped Status Light Controller

This peripheral sits on a 32-bit fetch/store bus and drives a panel of sixteen status lights. The panel has a master on/off switch, a four-bit brightness level and one bit per light. Software reaches the block through three word registers: a power word, a level word and a light-mask word. Their byte addresses are counted from a base of 100.

The meaning of a store depends on its value. Any nonzero value written to the power word switches the panel on, and zero switches it off. The level and mask words take only their low field from the written data, and the upper data bits have no effect. Address, operation and data are examined in parallel in one combinational decode. A mapped access is acknowledged in the same cycle it is presented, and a store takes effect at the next clock edge.

A request to any address outside the three words gets no acknowledge, so the surrounding bus logic can report it as an error.

Top module: `status_light_ctrl`

## Requirements
- R1: After a synchronous active-low reset, disp_on is 0, level is 0 and lights is 0.
- R2: A store to byte addresses 100 to 103 sets disp_on to 1 at the next clock edge if the 32-bit data is nonzero, and to 0 if the data is zero.
- R3: A store to byte addresses 104 to 107 loads level from data bits 3:0 at the next clock edge; data bits 31:4 have no effect.
- R4: A store to byte addresses 108 to 111 loads lights from data bits 15:0 at the next clock edge, data bit i driving lights bit i (1 = lit); data bits 31:16 have no effect.
- R5: A fetch from byte addresses 100 to 103 returns exactly 1 on rdata while the panel is on, and 0 while it is off.
- R6: A fetch from 104 to 107 returns level in bits 3:0, and a fetch from 108 to 111 returns lights in bits 15:0; all other rdata bits are 0.
- R7: A request to any byte address outside 100 to 111 leaves ack at 0 and rdata at 0, and changes none of disp_on, level or lights.
- R8: ack equals 1 in the same cycle as any request, fetch or store, to byte addresses 100 to 111, and is 0 whenever req is 0.
- R9: A fetch changes none of disp_on, level or lights, and rdata is 0 in any cycle without an acknowledged fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus request valid this cycle |
| we | input | 1 | 1 = store, 0 = fetch |
| addr | input | 16 | Byte address |
| wdata | input | 32 | Store data |
| ack | output | 1 | Request accepted (mapped address) |
| rdata | output | 32 | Fetch data, zero when not an acknowledged fetch |
| disp_on | output | 1 | Panel master enable |
| level | output | 4 | Brightness, 0 dim to 15 bright |
| lights | output | 16 | Per-light enables |

## Verification
Directed stores to the power word alternate between zero, a value with only bit 31 set and small values. This separates a true any-bit test from a test of bit 0 alone or of the low field. Level and mask stores carry noise in their upper bits, which exposes any leakage past the used field. Every byte offset inside each word is used, together with the addresses just below 100 and just above 111. These show whether the decode ignores the two low address bits and stops exactly at the word edges. A long pseudo-random mix of fetches, stores and stray addresses is then compared each cycle against a behavioural model, so any mismatch in the read mux or any unintended state change shows up.

// File: rtl/slc_pkg.sv
// Shared types for the status light controller.
// Assumes three consecutive word registers starting at a word-aligned base.
package slc_pkg;
    localparam int N_REGS = 3;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_POWER = 2'd1,
        SEL_LEVEL = 2'd2,
        SEL_MASK  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/slc_decode.sv
// Address decode: compares the word address against each register slot in
// parallel and qualifies the hit with request and direction.
// Assumes BASE_ADDR is a multiple of four; address bits 1:0 are ignored.
module slc_decode
    import slc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 100
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              wr_en,
    output logic              rd_en,
    output logic              ack
);
    localparam logic [ADDR_W-1:0] BASE_WORD = ADDR_W'(BASE_ADDR / 4);

    logic [ADDR_W-1:0] word;
    logic [N_REGS-1:0] hit;

    // Strip byte offset by shifting the full address.
    assign word = addr >> 2;

    for (genvar k = 0; k < N_REGS; k++) begin : g_slot
        // One comparator per register slot.
        assign hit[k] = (word == BASE_WORD + ADDR_W'(k));
    end

    // Turn the slot hits into a register select.
    always_comb begin
        if (hit[0])      sel = SEL_POWER;
        else if (hit[1]) sel = SEL_LEVEL;
        else if (hit[2]) sel = SEL_MASK;
        else             sel = SEL_NONE;
    end

    assign ack   = req && (hit != '0);
    assign wr_en = ack && we;
    assign rd_en = ack && !we;
endmodule

// File: rtl/slc_regs.sv
// Panel state: master enable, brightness level and light mask.
// Updates only on an acknowledged store; power store is value dependent.
module slc_regs
    import slc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BRIGHT_W = 4,
    parameter int N_LIGHTS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic                disp_on,
    output logic [BRIGHT_W-1:0] level,
    output logic [N_LIGHTS-1:0] lights
);
    // Master enable: any nonzero store turns on, zero turns off.
    always_ff @(posedge clk) begin
        if (!rst_n)                          disp_on <= 1'b0;
        else if (wr_en && sel == SEL_POWER)  disp_on <= (wdata != '0);
    end

    // Brightness takes the low field only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          level <= '0;
        else if (wr_en && sel == SEL_LEVEL)  level <= wdata[BRIGHT_W-1:0];
    end

    // Light mask takes the low field only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lights <= '0;
        else if (wr_en && sel == SEL_MASK)   lights <= wdata[N_LIGHTS-1:0];
    end

    // R2
    power_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_POWER && wdata != '0) |=> disp_on);
    // R2
    power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_POWER && wdata == '0) |=> !disp_on);
    // R3
    level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LEVEL) |=> level == $past(wdata[BRIGHT_W-1:0]));
    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_MASK) |=> lights == $past(wdata[N_LIGHTS-1:0]));
    // R9
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(disp_on) && $stable(level) && $stable(lights)));
endmodule

// File: rtl/slc_rdmux.sv
// Fetch data path: selects the addressed register, zero-extended.
// Drives zero in any cycle without an acknowledged fetch.
module slc_rdmux
    import slc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BRIGHT_W = 4,
    parameter int N_LIGHTS = 16
) (
    input  logic                rd_en,
    input  reg_sel_e            sel,
    input  logic                disp_on,
    input  logic [BRIGHT_W-1:0] level,
    input  logic [N_LIGHTS-1:0] lights,
    output logic [DATA_W-1:0]   rdata
);
    // Pick the register for the fetch, power reads back as exactly 1.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_POWER: rdata = {{(DATA_W-1){1'b0}}, disp_on};
                SEL_LEVEL: rdata = {{(DATA_W-BRIGHT_W){1'b0}}, level};
                SEL_MASK:  rdata = {{(DATA_W-N_LIGHTS){1'b0}}, lights};
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/status_light_ctrl.sv
// Top of the status light controller: decode, panel state and read mux.
// Single-cycle bus: ack and rdata are combinational, stores land at the edge.
module status_light_ctrl
    import slc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BASE_ADDR = 100,
    parameter int BRIGHT_W  = 4,
    parameter int N_LIGHTS  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                ack,
    output logic [DATA_W-1:0]   rdata,
    output logic                disp_on,
    output logic [BRIGHT_W-1:0] level,
    output logic [N_LIGHTS-1:0] lights
);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 4 * N_REGS - 1);

    reg_sel_e sel;
    logic     wr_en;
    logic     rd_en;

    slc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .req(req), .we(we), .addr(addr),
        .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .ack(ack)
    );

    slc_regs #(.DATA_W(DATA_W), .BRIGHT_W(BRIGHT_W), .N_LIGHTS(N_LIGHTS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
        .disp_on(disp_on), .level(level), .lights(lights)
    );

    slc_rdmux #(.DATA_W(DATA_W), .BRIGHT_W(BRIGHT_W), .N_LIGHTS(N_LIGHTS)) u_rdmux (
        .rd_en(rd_en), .sel(sel), .disp_on(disp_on), .level(level),
        .lights(lights), .rdata(rdata)
    );

    // R7
    unmapped_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (addr < LO_ADDR || addr > HI_ADDR)) |-> (!ack && rdata == '0));
    // R8
    mapped_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr >= LO_ADDR && addr <= HI_ADDR) |-> ack);
    // R8
    idle_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !ack);
    // R5
    power_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !we && addr <= LO_ADDR + 3) |-> (rdata == DATA_W'(disp_on)));
endmodule

// File: tb/status_light_ctrl_test.sv
`timescale 1ns/1ps
module status_light_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic        disp_on;
    logic [3:0]  level;
    logic [15:0] lights;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state
    int m_on  = 0;
    int m_lvl = 0;
    int m_lit = 0;

    always #2.5 clk = ~clk;

    status_light_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .disp_on(disp_on),
        .level(level), .lights(lights)
    );

    function automatic bit mapped(input int a);
        return (a >= 100) && (a <= 111);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of the panel state
    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_lvl = 0; m_lit = 0;
        end else if (req && we && mapped(int'(addr))) begin
            case ((int'(addr) - 100) / 4)
                0: m_on  = (wdata != 0) ? 1 : 0;
                1: m_lvl = int'(wdata) & 15;
                default: m_lit = int'(wdata) & 32'hFFFF;
            endcase
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int    exp_rd;
            string rtag;
            exp_rd = 0;
            rtag   = "R9";
            if (req && !mapped(int'(addr))) rtag = "R7";
            if (req && !we && mapped(int'(addr))) begin
                case ((int'(addr) - 100) / 4)
                    0: begin exp_rd = m_on;  rtag = "R5"; end
                    1: begin exp_rd = m_lvl; rtag = "R6"; end
                    default: begin exp_rd = m_lit; rtag = "R6"; end
                endcase
            end
            check((req && !mapped(int'(addr))) ? "R7 ack" : "R8 ack",
                  int'(ack), (req && mapped(int'(addr))) ? 1 : 0);
            check(rtag, int'(rdata), exp_rd);
            check("R2 disp_on", int'(disp_on), m_on);
            check("R3 level", int'(level), m_lvl);
            check("R4 lights", int'(lights), m_lit);
        end
    end

    task automatic txn(input bit r, input bit w, input int a, input logic [31:0] d);
        @(posedge clk);
        #1;
        req = r; we = w; addr = a[15:0]; wdata = d;
    endtask

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 disp_on", int'(disp_on), 0);
        check("R1 level", int'(level), 0);
        check("R1 lights", int'(lights), 0);

        // R2 value-dependent power word
        txn(1, 1, 100, 32'h8000_0000);
        txn(1, 0, 101, 0);
        txn(1, 1, 102, 32'h0);
        txn(1, 0, 103, 0);
        txn(1, 1, 103, 32'h2);
        // R3 upper bits ignored
        txn(1, 1, 104, 32'hFFFF_FFF5);
        txn(1, 0, 107, 0);
        txn(1, 1, 106, 32'h0000_0010);
        // R4 upper bits ignored
        txn(1, 1, 108, 32'hABCD_8001);
        txn(1, 0, 111, 0);
        txn(1, 1, 110, 32'h0001_0000);
        txn(1, 1, 109, 32'h0000_5A5A);
        // R7 edges of the window
        txn(1, 1, 99, 32'hFFFF_FFFF);
        txn(1, 1, 112, 32'h0);
        txn(1, 0, 96, 0);
        txn(1, 0, 112, 0);
        // R8 idle cycle with mapped address
        txn(0, 1, 100, 32'h0);
        txn(0, 0, 104, 0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int a;
            logic [31:0] d;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (lf[3:0])
                4'd12: a = 96 + int'(lf[5:4]);
                4'd13: a = 112 + int'(lf[5:4]);
                4'd14: a = int'(lf[15:0]);
                4'd15: a = 100;
                default: a = 100 + int'(lf[3:0]);
            endcase
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            d = (lf[6:4] == 3'd0) ? 32'h0 : (lf ^ 32'h9E37_79B9);
            txn(lf[9:8] != 2'd0, lf[11], a, d);
        end
        txn(0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule